// File: doc/BRIEF.md
# Multiplexed measurement serial transmitter

This block takes three parallel measurement words and sends them, over and over, on one output line as a fixed serial frame. The three words are a jitter reading, a loop-frequency reading and a slicer level. Monitoring equipment or a logic analyser watches this single pin. It finds each frame by the rising edge of its start bit and decodes the fields by counting bit times.

Each bit is held on the line for a fixed number of clocks. A frame begins with a high start bit, followed by the jitter word. Two marker bits, low then high, come next, followed by the frequency word. Another low-then-high pair comes next, then the level word, then three low tail bits. The line stays low for the rest of the frame. All three words are sampled into a shadow register at the moment a frame begins. A one-clock strobe marks the first clock of every start bit. With the enable low, or during reset, the line is quiet and the frame restarts from its beginning.

Top module: `meas_serial_tx`

## Requirements
- R1: With the enable held high, each bit slot lasts CLKS_PER_BIT clocks (default 4). A frame is FRAME_SLOTS slots (default 64), so frame starts recur every 256 clocks with no gap.
- R2: Slot 0 of every frame drives the line high.
- R3: Slots 1 to 10 carry the 10-bit jitter word, with bit 9 in slot 1 and bit 0 in slot 10.
- R4: Slots 11 and 23 drive the line low. Slots 12 and 24 drive it high.
- R5: Slots 13 to 22 carry the 10-bit frequency word, with bit 9 in slot 13 and bit 0 in slot 22.
- R6: Slots 25 to 32 carry the 8-bit level word, with bit 7 in slot 25 and bit 0 in slot 32. Slots 33, 34 and 35 are low.
- R7: Slots 36 to 63 (the pause) drive the line low.
- R8: The three words go out as sampled on the clock edge that begins the frame. Input changes later in that frame do not alter it.
- R9: The frame strobe is high for exactly one clock, in the same cycle the line first shows the start bit, and at no other time.
- R10: While reset is high or the enable is low, the line and the strobe are low one clock after the edge that samples it. The first edge that samples the enable high (with reset low) starts a new frame at slot 0, so the strobe and the start bit appear in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmit enable; low holds the frame at its beginning |
| jitter_in | input | JIT_W (10) | Jitter measurement word |
| freq_in | input | FRQ_W (10) | Loop frequency measurement word |
| level_in | input | LVL_W (8) | Slicer level word |
| ser_out | output | 1 | Registered serial line |
| frame_stb | output | 1 | Registered one-clock pulse at each start bit |

## Verification
The bench builds the block with its default parameters: four clocks per bit, 64 slots and word widths 10, 10 and 8. With these values the fixed slot positions above are exactly the ones checked, and a whole 256-clock frame is short enough for the run to cover many frames. These include all-ones, all-zeros, alternating and random words, a word change in the middle of a frame, and the enable and the reset both being dropped in the middle of a frame.

// File: rtl/meas_tx_pkg.sv
package meas_tx_pkg;

  // number of low slots that follow the level word
  localparam int TAIL_ZERO_SLOTS = 3;

  typedef enum logic [2:0] {
    SK_ZERO,
    SK_ONE,
    SK_JIT,
    SK_FRQ,
    SK_LVL
  } slot_kind_e;

  // first slot of each field, derived from word widths
  function automatic int jit_first(int jw);
    jit_first = 1 + 0 * jw;
  endfunction

  function automatic int frq_first(int jw);
    frq_first = 1 + jw + 2;
  endfunction

  function automatic int lvl_first(int jw, int fw);
    lvl_first = 1 + jw + 2 + fw + 2;
  endfunction

  function automatic int pause_first(int jw, int fw, int lw);
    pause_first = lvl_first(jw, fw) + lw + TAIL_ZERO_SLOTS;
  endfunction

  function automatic slot_kind_e slot_kind(int s, int jw, int fw, int lw);
    int f0;
    int l0;
    f0 = frq_first(jw);
    l0 = lvl_first(jw, fw);
    if (s == 0)                         slot_kind = SK_ONE;
    else if (s < 1 + jw)                slot_kind = SK_JIT;
    else if (s == 1 + jw)               slot_kind = SK_ZERO;
    else if (s == 2 + jw)               slot_kind = SK_ONE;
    else if (s < f0 + fw)               slot_kind = SK_FRQ;
    else if (s == f0 + fw)              slot_kind = SK_ZERO;
    else if (s == f0 + fw + 1)          slot_kind = SK_ONE;
    else if (s < l0 + lw)               slot_kind = SK_LVL;
    else                                slot_kind = SK_ZERO;
  endfunction

  // bit of the field word carried by slot s, most significant first
  function automatic int slot_index(int s, int jw, int fw, int lw);
    slot_kind_e k;
    k = slot_kind(s, jw, fw, lw);
    case (k)
      SK_JIT:  slot_index = jw - 1 - (s - jit_first(jw));
      SK_FRQ:  slot_index = fw - 1 - (s - frq_first(jw));
      SK_LVL:  slot_index = lw - 1 - (s - lvl_first(jw, fw));
      default: slot_index = 0;
    endcase
  endfunction

endpackage

// File: rtl/meas_tx_timer.sv
module meas_tx_timer #(
  parameter int CLKS_PER_BIT = 4,
  parameter int FRAME_SLOTS  = 64,
  localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1,
  localparam int SL_W = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [SL_W-1:0] slot,
  output logic            frame_go
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(FRAME_SLOTS - 1);

  logic [PH_W-1:0] phase_q;
  logic [SL_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      slot_q  <= (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign slot     = slot_q;
  assign frame_go = !rst && en && (phase_q == '0) && (slot_q == '0);

endmodule

// File: rtl/meas_tx_shadow.sv
module meas_tx_shadow #(
  parameter int JIT_W = 10,
  parameter int FRQ_W = 10,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [JIT_W-1:0] jit_d,
  input  logic [FRQ_W-1:0] frq_d,
  input  logic [LVL_W-1:0] lvl_d,
  output logic [JIT_W-1:0] jit_q,
  output logic [FRQ_W-1:0] frq_q,
  output logic [LVL_W-1:0] lvl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      jit_q <= '0;
      frq_q <= '0;
      lvl_q <= '0;
    end else if (load) begin
      jit_q <= jit_d;
      frq_q <= frq_d;
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/meas_tx_slot_map.sv
module meas_tx_slot_map
  import meas_tx_pkg::*;
#(
  parameter int JIT_W       = 10,
  parameter int FRQ_W       = 10,
  parameter int LVL_W       = 8,
  parameter int FRAME_SLOTS = 64
) (
  input  logic [JIT_W-1:0]       jit_q,
  input  logic [FRQ_W-1:0]       frq_q,
  input  logic [LVL_W-1:0]       lvl_q,
  output logic [FRAME_SLOTS-1:0] frame_bits
);

  for (genvar g = 0; g < FRAME_SLOTS; g++) begin : g_slot
    localparam slot_kind_e KIND = slot_kind(g, JIT_W, FRQ_W, LVL_W);
    localparam int         IDX  = slot_index(g, JIT_W, FRQ_W, LVL_W);
    if (KIND == SK_JIT) begin : g_jit
      assign frame_bits[g] = jit_q[IDX];
    end else if (KIND == SK_FRQ) begin : g_frq
      assign frame_bits[g] = frq_q[IDX];
    end else if (KIND == SK_LVL) begin : g_lvl
      assign frame_bits[g] = lvl_q[IDX];
    end else if (KIND == SK_ONE) begin : g_one
      assign frame_bits[g] = 1'b1;
    end else begin : g_zero
      assign frame_bits[g] = 1'b0;
    end
  end

endmodule

// File: rtl/meas_serial_tx.sv
module meas_serial_tx #(
  parameter int CLKS_PER_BIT = 4,
  parameter int FRAME_SLOTS  = 64,
  parameter int JIT_W        = 10,
  parameter int FRQ_W        = 10,
  parameter int LVL_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [JIT_W-1:0] jitter_in,
  input  logic [FRQ_W-1:0] freq_in,
  input  logic [LVL_W-1:0] level_in,
  output logic             ser_out,
  output logic             frame_stb
);

  localparam int SL_W = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1;

  logic [SL_W-1:0]        slot;
  logic                   frame_go;
  logic [JIT_W-1:0]       jit_s;
  logic [FRQ_W-1:0]       frq_s;
  logic [LVL_W-1:0]       lvl_s;
  logic [FRAME_SLOTS-1:0] frame_bits;
  logic                   ser_q;
  logic                   stb_q;

  meas_tx_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .FRAME_SLOTS (FRAME_SLOTS)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .slot    (slot),
    .frame_go(frame_go)
  );

  meas_tx_shadow #(
    .JIT_W(JIT_W),
    .FRQ_W(FRQ_W),
    .LVL_W(LVL_W)
  ) shadow_i (
    .clk  (clk),
    .rst  (rst),
    .load (frame_go),
    .jit_d(jitter_in),
    .frq_d(freq_in),
    .lvl_d(level_in),
    .jit_q(jit_s),
    .frq_q(frq_s),
    .lvl_q(lvl_s)
  );

  meas_tx_slot_map #(
    .JIT_W      (JIT_W),
    .FRQ_W      (FRQ_W),
    .LVL_W      (LVL_W),
    .FRAME_SLOTS(FRAME_SLOTS)
  ) map_i (
    .jit_q     (jit_s),
    .frq_q     (frq_s),
    .lvl_q     (lvl_s),
    .frame_bits(frame_bits)
  );

  // slot 0 is a constant high, so the shadow being loaded on the same
  // edge never matters for the start bit
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ser_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      ser_q <= frame_bits[slot];
      stb_q <= frame_go;
    end
  end

  assign ser_out   = ser_q;
  assign frame_stb = stb_q;

endmodule

// File: rtl/meas_tx_chk.sv
module meas_tx_chk
  import meas_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int FRAME_SLOTS  = 64,
  parameter int JIT_W        = 10,
  parameter int FRQ_W        = 10,
  parameter int LVL_W        = 8
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic ser,
  input logic stb
);

  localparam int TOT   = CLKS_PER_BIT * FRAME_SLOTS;
  localparam int POS_W = $clog2(TOT + 2);
  localparam int PAUSE_CLK = pause_first(JIT_W, FRQ_W, LVL_W) * CLKS_PER_BIT;

  logic [POS_W-1:0] pos_q;
  logic             valid_q;

  // clocks elapsed since the last strobe was seen
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos_q   <= '0;
      valid_q <= 1'b0;
    end else if (stb) begin
      pos_q   <= POS_W'(1);
      valid_q <= 1'b1;
    end else if (pos_q <= POS_W'(TOT)) begin
      pos_q   <= pos_q + 1'b1;
    end
  end

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  // R2
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> ser);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ser && !stb));

  // R10
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!ser && !stb));

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && en && !stb && ((int'(pos_q) % CLKS_PER_BIT) != 0)) |-> $stable(ser));

  // R1
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && en && (pos_q == POS_W'(TOT))) |-> stb);

  // R7
  pause_low_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && en && !stb && (int'(pos_q) >= PAUSE_CLK)) |-> !ser);

endmodule

bind meas_serial_tx meas_tx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .FRAME_SLOTS (FRAME_SLOTS),
  .JIT_W       (JIT_W),
  .FRQ_W       (FRQ_W),
  .LVL_W       (LVL_W)
) chk_i (
  .clk(clk),
  .rst(rst),
  .en (en),
  .ser(ser_out),
  .stb(frame_stb)
);

// File: tb/meas_serial_tx_tb_top.sv
module meas_serial_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [9:0] jitter_in = '0;
  logic [9:0] freq_in   = '0;
  logic [7:0] level_in  = '0;
  logic       ser_out;
  logic       frame_stb;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit done       = 1'b0;

  always #10 clk = ~clk;

  meas_serial_tx dut_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .jitter_in(jitter_in),
    .freq_in  (freq_in),
    .level_in (level_in),
    .ser_out  (ser_out),
    .frame_stb(frame_stb)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic check_word(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // ---------------- behavioural reference ----------------
  bit    frame_q[$];
  int    m_pos = 0;
  logic  m_ser = 1'b0;
  logic  m_stb = 1'b0;
  string m_tag = "R10";

  function automatic string tag_of(int s);
    if (s == 0)                          return "R2";
    if (s <= 10)                         return "R3";
    if (s == 11 || s == 12)              return "R4";
    if (s <= 22)                         return "R5";
    if (s == 23 || s == 24)              return "R4";
    if (s <= 35)                         return "R6";
    return "R7";
  endfunction

  task automatic build_frame(input logic [9:0] j, input logic [9:0] f, input logic [7:0] l);
    frame_q.delete();
    frame_q.push_back(1'b1);
    for (int i = 9; i >= 0; i--) frame_q.push_back(j[i]);
    frame_q.push_back(1'b0);
    frame_q.push_back(1'b1);
    for (int i = 9; i >= 0; i--) frame_q.push_back(f[i]);
    frame_q.push_back(1'b0);
    frame_q.push_back(1'b1);
    for (int i = 7; i >= 0; i--) frame_q.push_back(l[i]);
    while (frame_q.size() < 64) frame_q.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (rst || !en) begin
      m_pos = 0;
      m_ser = 1'b0;
      m_stb = 1'b0;
      m_tag = "R10";
    end else begin
      if (m_pos == 0) build_frame(jitter_in, freq_in, level_in);
      m_ser = frame_q[m_pos / 4];
      m_stb = (m_pos == 0);
      m_tag = (m_pos % 4 == 0) ? tag_of(m_pos / 4) : "R1";
      m_pos = (m_pos + 1) % 256;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check(m_tag, ser_out, m_ser, "serial line");
      check("R9", frame_stb, m_stb, "frame strobe");
      if (cycles > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
      end
    end
  end

  // ---------------- directed parts ----------------
  task automatic wait_strobe();
    do @(negedge clk); while (frame_stb !== 1'b1);
  endtask

  task automatic measure_period();
    int n = 0;
    wait_strobe();
    do begin
      @(negedge clk);
      n++;
    end while (frame_stb !== 1'b1 && n < 400);
    check_word("R1", n, 256, "clocks between strobes");
  endtask

  // R8: change words mid-frame, decode the frame, compare with start values
  task automatic capture_and_change(input logic [9:0] nj, input logic [9:0] nf, input logic [7:0] nl);
    logic [9:0] sj, sf, dj, df;
    logic [7:0] sl, dl;
    bit got[64];
    wait_strobe();
    sj = jitter_in; sf = freq_in; sl = level_in;
    for (int i = 0; i < 256; i++) begin
      if (i % 4 == 1) got[i / 4] = ser_out;
      if (i == 100) begin
        jitter_in = nj; freq_in = nf; level_in = nl;
      end
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) dj[9 - i] = got[1 + i];
    for (int i = 0; i < 10; i++) df[9 - i] = got[13 + i];
    for (int i = 0; i < 8; i++)  dl[7 - i] = got[25 + i];
    check_word("R8", int'(dj), int'(sj), "jitter word of frame");
    check_word("R8", int'(df), int'(sf), "frequency word of frame");
    check_word("R8", int'(dl), int'(sl), "level word of frame");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10", ser_out, 1'b0, "line in reset");
    check("R10", frame_stb, 1'b0, "strobe in reset");
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check("R10", ser_out, 1'b0, "line while disabled");

    jitter_in = 10'h3FF; freq_in = 10'h000; level_in = 8'hA5;
    en = 1'b1;
    @(negedge clk);
    check("R10", frame_stb, 1'b1, "strobe right after enable");
    check("R2", ser_out, 1'b1, "start bit right after enable");
    measure_period();
    measure_period();

    jitter_in = 10'h2AA; freq_in = 10'h155; level_in = 8'h5A;
    repeat (300) @(negedge clk);
    capture_and_change(10'h155, 10'h2AA, 8'hC3);
    capture_and_change(10'h001, 10'h200, 8'h81);

    // drop enable in the middle of a frame
    repeat (37) @(negedge clk);
    en = 1'b0;
    repeat (7) @(negedge clk);
    check("R10", ser_out, 1'b0, "line after enable dropped");
    check("R10", frame_stb, 1'b0, "strobe after enable dropped");
    en = 1'b1;
    @(negedge clk);
    check("R10", frame_stb, 1'b1, "restart strobe after enable");

    // reset in the middle of a frame
    repeat (61) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", ser_out, 1'b0, "line after mid-frame reset");
    rst = 1'b0;
    @(negedge clk);
    check("R10", frame_stb, 1'b1, "restart strobe after reset");

    for (int k = 0; k < 6; k++) begin
      jitter_in = 10'($urandom);
      freq_in   = 10'($urandom);
      level_in  = 8'($urandom);
      repeat (256) @(negedge clk);
    end
    measure_period();
    repeat (20) @(negedge clk);
    finish_up();
  end

endmodule